// File: doc/BRIEF.md
# MII Management Station Controller

This block runs clause-22 management frames toward an external PHY over a management clock and data pin pair. Software first picks a clock-divide code. It then loads an address register with the PHY number and the register number. A read starts on a rising transition of a command bit. A write starts as soon as software stores a value into the write-data register. While a frame is on the wire a busy flag stays high. When a read finishes, its 16-bit result is held on a read-data output.

Each frame has the following fields, sent MSB first: 32 preamble ones, start `01`, opcode (`10` read, `01` write), 5-bit PHY number, 5-bit register number, turnaround, then 16 data bits. The controller drives the data pin on the falling edge of the management clock. On reads it samples the pin just before the rising edge. The sequencer has these states: `ST_IDLE`, `ST_PREAMBLE`, `ST_HEADER`, `ST_TURN` and `ST_DATA`. Its transitions are:
- `ST_IDLE` → `ST_PREAMBLE` on an accepted start.
- `ST_PREAMBLE` → `ST_HEADER` at the falling clock that ends bit 31.
- `ST_HEADER` → `ST_TURN` after bit 45.
- `ST_TURN` → `ST_DATA` after bit 47.
- `ST_DATA` → `ST_IDLE` after bit 63.

Top module: `mgmt_station`

## Requirements
- R1: After reset, `busy`, `mdc` and `mdio_oe` are 0, `mdio_o` is 1 and `rd_data` is 0.
- R2: Register port selects: 0 = clock config, 1 = command, 2 = address (PHY number in bits 12:8, register number in bits 4:0), 3 = write data. A store to select 3 while idle sends a write frame. That frame is 32 ones, `01`, `01`, PHY, register, `10`, then the stored 16 bits, with `mdio_oe` high for all 64 bits.
- R3: A read frame carries opcode `10`. `mdio_oe` is high for bits 0 to 45 and low for bits 46 to 63 (turnaround and data). `mdio_oe` is 0 whenever the block is idle.
- R4: On a read, the 16 data bits are sampled from `mdio_i` around each rising `mdc` edge, MSB first. They appear on `rd_data` on the cycle `busy` clears. `rd_data` changes at no other time, and a write leaves it unchanged.
- R5: `busy` rises on the cycle after an accepted start. It stays high for exactly 64 `mdc` periods and falls with the last falling `mdc` edge. `mdc` is 0 while idle.
- R6: Only a 0→1 transition of command bit 0 starts a read. Storing 1 again while the bit is already 1 starts nothing.
- R7: Stores to the address or write-data selects while `busy` is high are ignored. They neither start a frame nor alter the address used later.
- R8: Config bits 4:2 pick the `mdc` period in host clocks: codes 0 to 7 give 4, 4, 6, 8, 10, 14, 20, 28, with equal high and low halves. The reset code is 7 (28 clocks).
- R9: `mdio_o` changes only together with a falling `mdc` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register store strobe |
| reg_sel | input | 2 | Register select (0 config, 1 command, 2 address, 3 write data) |
| reg_wdata | input | 16 | Register store value |
| busy | output | 1 | Frame in progress |
| rd_data | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data drive enable |
| mdio_i | input | 1 | Management data in |

## Verification
The hardest case to create is a store that lands during a frame and must be ignored. An ignored address store leaves no mark until a later frame reuses the old address. The bench covers this by poking both the address and write-data selects in the middle of a write. It then confirms that no new frame starts, and issues a read without reloading the address so that the captured header exposes any corruption. A bench PHY model drives known read data after each falling `mdc` edge. Random frames with random divider codes check the framing and timing.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    typedef enum logic [1:0] {
        SEL_CFG   = 2'd0,
        SEL_CMD   = 2'd1,
        SEL_ADDR  = 2'd2,
        SEL_WDATA = 2'd3
    } sel_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREAMBLE,
        ST_HEADER,
        ST_TURN,
        ST_DATA
    } st_e;

    localparam int HALF_W = 4;

    // half of the mdc period, in host clocks, for each divide code
    function automatic logic [HALF_W-1:0] half_of(input logic [2:0] code);
        logic [HALF_W-1:0] h;
        unique case (code)
            3'd0, 3'd1: h = 4'd2;
            3'd2:       h = 4'd3;
            3'd3:       h = 4'd4;
            3'd4:       h = 4'd5;
            3'd5:       h = 4'd7;
            3'd6:       h = 4'd10;
            default:    h = 4'd14;
        endcase
        return h;
    endfunction
endpackage

// File: rtl/mdc_gen.sv
module mdc_gen #(
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HALF_W-1:0] half,
    output logic              mdc,
    output logic              rise,
    output logic              fall
);
    logic [HALF_W-1:0] cnt_q;
    logic              wrap;

    assign wrap = en && (cnt_q == half - HALF_W'(1));
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= !mdc;
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end
endmodule

// File: rtl/frame_engine.sv
module frame_engine
    import mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_rd,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regn,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);
    localparam int FRAME_LEN = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int LAST      = FRAME_LEN - 1;
    localparam int HDR_LAST  = PRE_LEN + 4 + 2 * ADDR_W - 1;
    localparam int TA_LAST   = HDR_LAST + 2;

    st_e                  state_q, state_d;
    logic [CNT_W-1:0]     bit_q;
    logic [FRAME_LEN-1:0] sr_q, frame;
    logic [DATA_W-1:0]    rx_q;
    logic                 rd_q;

    assign frame = {{PRE_LEN{1'b1}}, 2'b01, (start_rd ? 2'b10 : 2'b01),
                    phy, regn, 2'b10, (start_rd ? {DATA_W{1'b0}} : wdata)};
    assign busy  = (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_PREAMBLE;
            ST_PREAMBLE: if (fall && bit_q == CNT_W'(PRE_LEN - 1)) state_d = ST_HEADER;
            ST_HEADER:   if (fall && bit_q == CNT_W'(HDR_LAST)) state_d = ST_TURN;
            ST_TURN:     if (fall && bit_q == CNT_W'(TA_LAST)) state_d = ST_DATA;
            ST_DATA:     if (fall && bit_q == CNT_W'(LAST)) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            sr_q    <= '0;
            rx_q    <= '0;
            rd_q    <= 1'b0;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
            rd_data <= '0;
        end else if (state_q == ST_IDLE) begin
            if (start) begin
                sr_q    <= frame;
                bit_q   <= '0;
                rd_q    <= start_rd;
                rx_q    <= '0;
                mdio_o  <= frame[LAST];
                mdio_oe <= 1'b1;
            end
        end else begin
            if (rise && rd_q && state_q == ST_DATA)
                rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            if (fall) begin
                if (state_d == ST_IDLE) begin
                    mdio_o  <= 1'b1;
                    mdio_oe <= 1'b0;
                    if (rd_q) rd_data <= rx_q;
                end else begin
                    bit_q   <= bit_q + CNT_W'(1);
                    sr_q    <= sr_q << 1;
                    mdio_o  <= sr_q[LAST-1];
                    mdio_oe <= !(rd_q && (state_d == ST_TURN || state_d == ST_DATA));
                end
            end
        end
    end
endmodule

// File: rtl/mgmt_station.sv
module mgmt_station
    import mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam int PHY_LSB = 8;
    localparam int DIV_LSB = 2;

    logic [2:0]        div_q;
    logic              cmd_q;
    logic [ADDR_W-1:0] phy_q, regn_q;
    logic              start_rd, start_wr, rise, fall;

    assign start_rd = reg_wr && (reg_sel == SEL_CMD) && reg_wdata[0] && !cmd_q && !busy;
    assign start_wr = reg_wr && (reg_sel == SEL_WDATA) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= 3'd7;
            cmd_q  <= 1'b0;
            phy_q  <= '0;
            regn_q <= '0;
        end else if (reg_wr) begin
            unique case (reg_sel)
                SEL_CFG:  div_q <= reg_wdata[DIV_LSB +: 3];
                SEL_CMD:  cmd_q <= reg_wdata[0];
                SEL_ADDR: if (!busy) begin
                    phy_q  <= reg_wdata[PHY_LSB +: ADDR_W];
                    regn_q <= reg_wdata[0 +: ADDR_W];
                end
                default: ;
            endcase
        end
    end

    mdc_gen #(.HALF_W(HALF_W)) u_mdc (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .half (half_of(div_q)),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    frame_engine #(.PRE_LEN(PRE_LEN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_rd || start_wr),
        .start_rd(start_rd),
        .phy     (phy_q),
        .regn    (regn_q),
        .wdata   (reg_wdata),
        .rise    (rise),
        .fall    (fall),
        .mdio_i  (mdio_i),
        .busy    (busy),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/mgmt_station_chk.sv
module mgmt_station_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [DATA_W-1:0] rd_data,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe
);
    p_mdio_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));

    p_idle_mdc_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> $fell(busy));

    p_start_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe && mdio_o && !mdc));
endmodule

bind mgmt_station mgmt_station_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .rd_data(rd_data),
    .mdc    (mdc),
    .mdio_o (mdio_o),
    .mdio_oe(mdio_oe)
);

// File: tb/mgmt_station_tb.sv
module mgmt_station_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;
    logic [15:0] rd_data;

    int          vec = 0, bad = 0;
    int          cyc = 0, rises = 0, falls = 0, busy_cyc = 0;
    int          last_rise = 0, per_min = 0, per_max = 0;
    logic        prev_mdc = 1'b0, prev_busy = 1'b0;
    logic [63:0] cap_o, cap_oe;
    logic [15:0] phy_val = 16'd0;

    always #5 clk = !clk;

    mgmt_station u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy(busy), .rd_data(rd_data), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model and wire monitor, all at the inactive edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_mdc  <= mdc;
        prev_busy <= busy;
        if (busy && !prev_busy) begin
            rises <= 0; falls <= 0; busy_cyc <= 1;
            per_min <= 1000; per_max <= 0;
        end else begin
            if (busy) busy_cyc <= busy_cyc + 1;
            if (mdc && !prev_mdc) begin
                if (rises < 64) begin
                    cap_o[63-rises]  <= mdio_o;
                    cap_oe[63-rises] <= mdio_oe;
                end
                if (rises > 0) begin
                    if (cyc - last_rise < per_min) per_min <= cyc - last_rise;
                    if (cyc - last_rise > per_max) per_max <= cyc - last_rise;
                end
                last_rise <= cyc;
                rises <= rises + 1;
            end
            if (!mdc && prev_mdc) begin
                if (falls + 1 >= 48 && falls + 1 < 64) mdio_i <= phy_val[63-(falls+1)];
                else mdio_i <= 1'b1;
                falls <= falls + 1;
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int ratio_of(input logic [2:0] code);
        case (code)
            3'd0, 3'd1: return 4;
            3'd2: return 6;
            3'd3: return 8;
            3'd4: return 10;
            3'd5: return 14;
            3'd6: return 20;
            default: return 28;
        endcase
    endfunction

    task automatic wr(input logic [1:0] sel, input logic [15:0] val);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic run_tx(input logic rd, input logic [4:0] phy, input logic [4:0] regn,
                          input logic [15:0] data, input logic [2:0] code,
                          input logic set_cfg, input logic set_addr, input logic poke);
        logic [63:0] exp_f, exp_oe, mask;
        logic [15:0] rd_before;
        int ratio = ratio_of(code);
        if (set_cfg) wr(2'd0, {11'd0, code, 2'b00});
        if (set_addr) wr(2'd2, {3'd0, phy, 3'd0, regn});
        phy_val = data;
        rd_before = rd_data;
        if (rd) begin
            wr(2'd1, 16'd0);
            wr(2'd1, 16'd1);
        end else wr(2'd3, data);
        check(busy === 1'b1, "R5 busy after start", 64'(busy), 64'd1);
        if (poke) begin
            repeat (100) @(negedge clk);
            wr(2'd2, 16'h1F1F ^ {3'd0, phy, 3'd0, regn});
            wr(2'd3, ~data);
        end
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        check(busy_cyc == 64 * ratio, "R5 R8 busy length", 64'(busy_cyc), 64'(64 * ratio));
        check(per_min == ratio && per_max == ratio, "R8 mdc period", 64'(per_max), 64'(ratio));
        exp_f  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, regn, 2'b10, data};
        exp_oe = rd ? {46'h3FFF_FFFF_FFFF, 18'd0} : 64'hFFFF_FFFF_FFFF_FFFF;
        mask   = rd ? {46'h3FFF_FFFF_FFFF, 18'd0} : 64'hFFFF_FFFF_FFFF_FFFF;
        check(rises == 64 && (cap_o & mask) == (exp_f & mask),
              rd ? "R3 read frame" : "R2 write frame", cap_o & mask, exp_f & mask);
        check(cap_oe == exp_oe, "R3 drive enable pattern", cap_oe, exp_oe);
        if (rd) check(rd_data == data, "R4 read data", 64'(rd_data), 64'(data));
        else    check(rd_data == rd_before, "R4 write keeps rd_data", 64'(rd_data), 64'(rd_before));
        if (poke) begin
            logic seen = 1'b0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (busy) seen = 1'b1;
            end
            check(!seen, "R7 store during busy started no frame", 64'(seen), 64'd0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(negedge clk);
        bad++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !mdc && !mdio_oe && mdio_o && rd_data == 16'd0, "R1 reset state",
              {busy, mdc, mdio_oe, mdio_o, rd_data}, {4'b0001, 16'd0});

        // reset divider code 7, no config store
        run_tx(1'b0, 5'h15, 5'h0A, 16'hA5C3, 3'd7, 1'b0, 1'b1, 1'b0);
        run_tx(1'b1, 5'h01, 5'h1F, 16'hBEEF, 3'd0, 1'b1, 1'b1, 1'b0);

        // R6: command bit held at 1 does not restart
        wr(2'd1, 16'd1);
        @(negedge clk);
        check(!busy, "R6 held command bit no restart", 64'(busy), 64'd0);

        // R7: poke address and data mid write, then read without reloading address
        run_tx(1'b0, 5'h0C, 5'h03, 16'h1234, 3'd2, 1'b1, 1'b1, 1'b1);
        run_tx(1'b1, 5'h0C, 5'h03, 16'h8001, 3'd1, 1'b1, 1'b0, 1'b0);

        for (int k = 0; k < 12; k++) begin
            logic [31:0] r = $urandom;
            run_tx(r[0], r[5:1], r[10:6], r[26:11], r[29:27], 1'b1, 1'b1, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule